// File: doc/BRIEF.md
# Fine-Bin Calibrator and Interval Converter

This block turns raw time-to-digital measurements into signed intervals in picoseconds. Each raw word carries a coarse clock count and two fine codes. The fine codes are the number of delay taps a start hit and a stop hit have passed through. Delay taps are never equal in width, so a fixed bin width gives a large integral error. The block therefore learns the width of every tap from the data.

During learning, the upstream logic feeds words caused by hits that have no relation to the sampling clock. The block counts how often each fine code occurs, keeping one histogram per channel. A bin's share of the hits, times the clock period, gives its width. Once a fixed number of hits has been collected, learning stops by itself. A sequential pass then writes a table holding the centre time of every code: the widths of all lower bins plus half of its own.

During measuring, each word is converted in a fixed pipeline. The converted value is the coarse count times the clock period, plus the start centre time, minus the stop centre time, minus a constant zero-interval offset that the host sets.

Top module: `tdc_bin_calibrator`

## Requirements
- R1: After synchronous reset, `interval_valid` and `reject` are low, and they stay low until a conversion request arrives.
- R2: A request is a cycle with `raw_valid` high and `learn_sel` low. Fields of `raw_word`: stop code in bits [CODE_W-1:0], start code in bits [2*CODE_W-1:CODE_W], coarse count in the bits above. Two clock edges after the request, `interval_ps` equals round((coarse*P + C_start - C_stop - offset_fp)/16). P is the clock period in 1/16 ps (2000 ps, so 32000). `offset_fp` is in 1/16 ps.
- R3: The centre time of code i, in 1/16 ps, is floor(((2*S_i + h_i) * P) / 2^(HITS_LOG2+1)). Here h_i is the code's hit count and S_i is the sum of the counts of all lower codes.
- R4: A rising edge of `learn_sel` while the block is idle starts learning. Learning first clears both histograms over 2^CODE_W cycles, so counts from an earlier run do not carry over. Words during the clear are not counted.
- R5: Each learn word adds one hit to its start code and one to its stop code. After exactly 2^HITS_LOG2 counted words, learning ends by itself, and further words do not change the table.
- R6: A histogram counter holds at its maximum value 2^CNT_W-1 instead of wrapping.
- R7: A request made before the table pass has finished produces a one-cycle `reject` pulse with the same two-edge latency, and no `interval_valid`. Starting a new learning run withdraws the table. `reject` and `interval_valid` are never high together.
- R8: Rounding goes to the nearest picosecond, with exact halves rounded toward plus infinity, and negative results come out in two's complement.
- R9: Learn words with the same code on consecutive cycles are each counted.
- R10: A code that got no hits has zero width: its centre time equals the total width of all lower codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_valid | input | 1 | Raw word strobe |
| raw_word | input | WORD_W | Packed coarse count, start code and stop code |
| learn_sel | input | 1 | High: words are histogram hits; low: words are conversion requests |
| offset_fp | input | OFF_W | Zero-interval offset in 1/16 ps |
| interval_ps | output | OUT_W | Signed converted interval in ps |
| interval_valid | output | 1 | Conversion result strobe |
| reject | output | 1 | Request refused because no table is ready |

## Verification
The bench probes the rounding boundary with offsets of 7, 8, 9 and 24 sixteenths on a zero-width code pair. A design that truncates, or rounds halves the wrong way, is off by one picosecond there. Learning uses long runs of the same code on consecutive cycles, so a read-modify-write hazard loses hits and shifts every higher centre. It also sends words past the hit total, so a design that does not stop on its own inflates the low codes. A second run drives one code far beyond the counter range and then checks a code that was busy only in the first run. This exposes wrapping counters, and histograms that are never cleared. Requests made before the first table, and during a relearn clear, must give a reject and no result.

// File: rtl/tdc_cal_pkg.sv
`timescale 1ns/1ps
package tdc_cal_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CLEAR,
    PH_ACC,
    PH_DRAIN,
    PH_BUILD,
    PH_FLUSH
  } cal_phase_t;
endpackage

// File: rtl/tdc_cal_channel.sv
`timescale 1ns/1ps
// One channel: hit histogram with read-modify-write forwarding, and the centre-time table.
module tdc_cal_channel #(
  parameter int CODE_W    = 10,
  parameter int CNT_W     = 18,
  parameter int HITS_LOG2 = 17,
  parameter int PERIOD_FP = 32000,
  parameter int TIME_W    = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_en,
  input  logic              bld_en,
  input  logic [CODE_W-1:0] sweep_addr,
  input  logic              hit_en,
  input  logic [CODE_W-1:0] code,
  output logic [TIME_W-1:0] code_time
);
  localparam int DEPTH  = 1 << CODE_W;
  localparam int SUM_W  = HITS_LOG2 + 2;
  localparam int PER_W  = $clog2(PERIOD_FP + 1);
  localparam int PROD_W = SUM_W + 1 + PER_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]  hist [DEPTH];
  logic [TIME_W-1:0] ctab [DEPTH];

  logic [CNT_W-1:0]  hist_rd;
  logic [CODE_W-1:0] raddr;
  logic              upd_v, fwd_v, bld_v;
  logic [CODE_W-1:0] upd_addr, bld_idx;
  logic [CNT_W-1:0]  fwd_val, cur, nxt;
  logic              we;
  logic [CODE_W-1:0] waddr;
  logic [CNT_W-1:0]  wdata;
  logic [SUM_W-1:0]  psum;
  logic [PROD_W-1:0] twice_plus, prod;
  logic [TIME_W-1:0] centre;

  assign raddr = bld_en ? sweep_addr : code;

  always_comb begin
    cur   = fwd_v ? fwd_val : hist_rd;
    nxt   = (cur == CNT_MAX) ? cur : cur + 1'b1;
    we    = clr_en | upd_v;
    waddr = clr_en ? sweep_addr : upd_addr;
    wdata = clr_en ? '0 : nxt;
  end

  always_ff @(posedge clk) begin
    if (we) hist[waddr] <= wdata;
    hist_rd <= hist[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_v    <= 1'b0;
      fwd_v    <= 1'b0;
      bld_v    <= 1'b0;
      upd_addr <= '0;
      fwd_val  <= '0;
      bld_idx  <= '0;
    end else begin
      upd_v    <= hit_en;
      upd_addr <= code;
      fwd_v    <= hit_en && upd_v && (code == upd_addr);
      fwd_val  <= nxt;
      bld_v    <= bld_en;
      bld_idx  <= sweep_addr;
    end
  end

  always_comb begin
    twice_plus = PROD_W'({psum, 1'b0}) + PROD_W'(hist_rd);
    prod       = twice_plus * PROD_W'(PERIOD_FP);
    centre     = TIME_W'(prod >> (HITS_LOG2 + 1));
  end

  always_ff @(posedge clk) begin
    if (rst || clr_en) psum <= '0;
    else if (bld_v)    psum <= psum + SUM_W'(hist_rd);
  end

  always_ff @(posedge clk) begin
    if (bld_v) ctab[bld_idx] <= centre;
    code_time <= ctab[code];
  end
endmodule

// File: rtl/tdc_cal_combine.sv
`timescale 1ns/1ps
// Coarse plus fine combination, offset removal and rounding to whole picoseconds.
module tdc_cal_combine #(
  parameter int COARSE_W  = 12,
  parameter int TIME_W    = 15,
  parameter int OFF_W     = 16,
  parameter int FRAC_BITS = 4,
  parameter int PERIOD_FP = 32000,
  parameter int OUT_W     = 32
) (
  input  logic [COARSE_W-1:0]     coarse,
  input  logic [TIME_W-1:0]       t_start,
  input  logic [TIME_W-1:0]       t_stop,
  input  logic [OFF_W-1:0]        offset,
  output logic signed [OUT_W-1:0] ps
);
  localparam int ACC_W = COARSE_W + TIME_W + OFF_W + 3;
  localparam int HALF  = 1 << (FRAC_BITS - 1);

  logic signed [ACC_W-1:0] total;

  always_comb begin
    total = $signed(ACC_W'(coarse)) * $signed(ACC_W'(PERIOD_FP))
          + $signed(ACC_W'(t_start)) - $signed(ACC_W'(t_stop))
          - $signed(ACC_W'(offset)) + $signed(ACC_W'(HALF));
    ps = OUT_W'(total >>> FRAC_BITS);
  end
endmodule

// File: rtl/tdc_bin_calibrator.sv
`timescale 1ns/1ps
module tdc_bin_calibrator
  import tdc_cal_pkg::*;
#(
  parameter int CODE_W    = 10,
  parameter int WORD_W    = 32,
  parameter int HITS_LOG2 = 17,
  parameter int CNT_W     = HITS_LOG2 + 1,
  parameter int PERIOD_PS = 2000,
  parameter int FRAC_BITS = 4,
  parameter int OFF_W     = 16,
  parameter int OUT_W     = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    raw_valid,
  input  logic [WORD_W-1:0]       raw_word,
  input  logic                    learn_sel,
  input  logic [OFF_W-1:0]        offset_fp,
  output logic signed [OUT_W-1:0] interval_ps,
  output logic                    interval_valid,
  output logic                    reject
);
  localparam int COARSE_W  = WORD_W - 2 * CODE_W;
  localparam int PERIOD_FP = PERIOD_PS << FRAC_BITS;
  localparam int TIME_W    = $clog2(PERIOD_FP + 1);
  localparam int HCNT_W    = HITS_LOG2 + 1;
  localparam logic [CODE_W-1:0] LAST_CODE = '1;
  localparam logic [HCNT_W-1:0] LAST_HIT  = HCNT_W'((1 << HITS_LOG2) - 1);

  cal_phase_t        phase;
  logic [CODE_W-1:0] sweep;
  logic [HCNT_W-1:0] hit_total;
  logic              ready, mode_q;
  logic              hit_fire, clr_en, bld_en, meas_req;
  logic              req_q, rdy_q;
  logic [COARSE_W-1:0] coarse_q;
  logic [CODE_W-1:0] ch_code [2];
  logic [TIME_W-1:0] ch_time [2];
  logic signed [OUT_W-1:0] comb_ps;

  assign ch_code[0] = raw_word[2*CODE_W-1:CODE_W];
  assign ch_code[1] = raw_word[CODE_W-1:0];
  assign hit_fire   = (phase == PH_ACC) && raw_valid && learn_sel;
  assign clr_en     = (phase == PH_CLEAR);
  assign bld_en     = (phase == PH_BUILD);
  assign meas_req   = raw_valid && !learn_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      sweep     <= '0;
      hit_total <= '0;
      ready     <= 1'b0;
      mode_q    <= 1'b0;
    end else begin
      mode_q <= learn_sel;
      case (phase)
        PH_IDLE: if (learn_sel && !mode_q) begin
          phase <= PH_CLEAR;
          sweep <= '0;
          ready <= 1'b0;
        end
        PH_CLEAR: begin
          sweep <= sweep + 1'b1;
          if (sweep == LAST_CODE) begin
            phase     <= PH_ACC;
            hit_total <= '0;
          end
        end
        PH_ACC: if (hit_fire) begin
          hit_total <= hit_total + 1'b1;
          if (hit_total == LAST_HIT) phase <= PH_DRAIN;
        end
        PH_DRAIN: begin
          phase <= PH_BUILD;
          sweep <= '0;
        end
        PH_BUILD: begin
          sweep <= sweep + 1'b1;
          if (sweep == LAST_CODE) phase <= PH_FLUSH;
        end
        PH_FLUSH: begin
          phase <= PH_IDLE;
          ready <= 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    tdc_cal_channel #(
      .CODE_W(CODE_W), .CNT_W(CNT_W), .HITS_LOG2(HITS_LOG2),
      .PERIOD_FP(PERIOD_FP), .TIME_W(TIME_W)
    ) i_chan (
      .clk(clk), .rst(rst), .clr_en(clr_en), .bld_en(bld_en),
      .sweep_addr(sweep), .hit_en(hit_fire), .code(ch_code[ch]),
      .code_time(ch_time[ch])
    );
  end

  tdc_cal_combine #(
    .COARSE_W(COARSE_W), .TIME_W(TIME_W), .OFF_W(OFF_W),
    .FRAC_BITS(FRAC_BITS), .PERIOD_FP(PERIOD_FP), .OUT_W(OUT_W)
  ) i_combine (
    .coarse(coarse_q), .t_start(ch_time[0]), .t_stop(ch_time[1]),
    .offset(offset_fp), .ps(comb_ps)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q          <= 1'b0;
      rdy_q          <= 1'b0;
      coarse_q       <= '0;
      interval_valid <= 1'b0;
      reject         <= 1'b0;
      interval_ps    <= '0;
    end else begin
      req_q          <= meas_req;
      rdy_q          <= ready;
      coarse_q       <= raw_word[WORD_W-1:2*CODE_W];
      interval_valid <= req_q && rdy_q;
      reject         <= req_q && !rdy_q;
      if (req_q && rdy_q) interval_ps <= comb_ps;
    end
  end
endmodule

// File: rtl/tdc_bin_calibrator_chk.sv
`timescale 1ns/1ps
module tdc_bin_calibrator_chk
  import tdc_cal_pkg::*;
#(
  parameter int HCNT_W = 18,
  parameter int TOTAL  = 131072
) (
  input logic              clk,
  input logic              rst,
  input logic              raw_valid,
  input logic              learn_sel,
  input logic              interval_valid,
  input logic              reject,
  input cal_phase_t        phase,
  input logic [HCNT_W-1:0] hit_total
);
  // R1: nothing comes out in the cycle right after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!interval_valid && !reject));

  // R7: a request gets exactly one of the two outcomes
  a_r7_one_outcome: assert property (@(posedge clk) disable iff (rst)
    !(interval_valid && reject));

  // R2: a result traces back to a request two edges earlier
  a_r2_result_has_request: assert property (@(posedge clk) disable iff (rst)
    interval_valid |-> ($past(raw_valid, 2) && !$past(learn_sel, 2)));

  // R7: a reject traces back to a request two edges earlier
  a_r7_reject_has_request: assert property (@(posedge clk) disable iff (rst)
    reject |-> ($past(raw_valid, 2) && !$past(learn_sel, 2)));

  // R7: a result only comes from a request made while idle
  a_r7_result_only_idle: assert property (@(posedge clk) disable iff (rst)
    interval_valid |-> ($past(phase, 2) == PH_IDLE));

  // R5: the counted-word total never passes its limit
  a_r5_hits_bounded: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ACC) |-> (32'(hit_total) < TOTAL));
endmodule

bind tdc_bin_calibrator tdc_bin_calibrator_chk #(
  .HCNT_W(HITS_LOG2 + 1), .TOTAL(1 << HITS_LOG2)
) i_chk (
  .clk(clk), .rst(rst), .raw_valid(raw_valid), .learn_sel(learn_sel),
  .interval_valid(interval_valid), .reject(reject),
  .phase(phase), .hit_total(hit_total)
);

// File: tb/test_tdc_bin_calibrator.sv
`timescale 1ns/1ps
module test_tdc_bin_calibrator;
  localparam int CODE_W = 4;
  localparam int HL2    = 6;
  localparam int CNTW   = 5;
  localparam int NWORDS = 1 << HL2;
  localparam int NCODES = 1 << CODE_W;
  localparam int CMAX   = (1 << CNTW) - 1;
  localparam int PFP    = 32000;

  localparam int START_CNT [16] = '{0,0,4,6,5,3,8,2,7,4,5,6,3,5,6,0};
  localparam int STOP_CNT  [16] = '{0,3,5,5,5,5,5,5,5,5,5,5,5,5,1,0};

  localparam int NV = 12;
  localparam int V_COARSE [NV] = '{0,0,0,0,0,3,0,5,1000,0,2,0};
  localparam int V_START  [NV] = '{0,0,0,0,0,15,0,7,9,2,14,8};
  localparam int V_STOP   [NV] = '{0,0,0,0,0,0,15,11,3,2,1,8};
  localparam int V_OFF    [NV] = '{0,7,8,9,24,5488,0,100,0,0,5488,16};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raw_valid = 1'b0;
  logic [31:0] raw_word = '0;
  logic learn_sel = 1'b0;
  logic [15:0] offset_fp = '0;
  logic signed [31:0] interval_ps;
  logic interval_valid, reject;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  int m_start [16];
  int m_stop  [16];

  always #10 clk = ~clk;

  tdc_bin_calibrator #(.CODE_W(CODE_W), .HITS_LOG2(HL2), .CNT_W(CNTW)) i_tdc_bin_calibrator (
    .clk(clk), .rst(rst), .raw_valid(raw_valid), .raw_word(raw_word),
    .learn_sel(learn_sel), .offset_fp(offset_fp), .interval_ps(interval_ps),
    .interval_valid(interval_valid), .reject(reject));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint centre_fp(input bit stop_ch, input int code);
    longint s = 0;
    longint c;
    for (int i = 0; i < code; i++) s += stop_ch ? m_stop[i] : m_start[i];
    c = stop_ch ? m_stop[code] : m_start[code];
    return ((2 * s + c) * PFP) >> (HL2 + 1);
  endfunction

  function automatic longint expect_ps(input int co, input int st, input int sp, input int off);
    longint r;
    r = longint'(co) * PFP + centre_fp(0, st) - centre_fp(1, sp) - off;
    return (r + 8) >>> 4;
  endfunction

  // Request, then sample two edges later
  task automatic measure(input int co, input int st, input int sp, input int off,
                         output longint got, output bit v, output bit rj);
    @(negedge clk);
    learn_sel = 1'b0;
    raw_valid = 1'b1;
    raw_word  = {co[23:0], st[3:0], sp[3:0]};
    offset_fp = off[15:0];
    @(negedge clk);
    raw_valid = 1'b0;
    @(negedge clk);
    got = longint'(interval_ps);
    v   = interval_valid;
    rj  = reject;
  endtask

  task automatic learn_run(input bit second, input bit probe);
    int seq_s [NWORDS];
    int seq_p [NWORDS];
    int idx;
    longint g;
    bit v, rj;
    if (!second) begin
      idx = 0;
      for (int c = 0; c < NCODES; c++)
        for (int k = 0; k < START_CNT[c]; k++) begin seq_s[idx] = c; idx++; end
      idx = 0;
      for (int c = 0; c < NCODES; c++)
        for (int k = 0; k < STOP_CNT[c]; k++) begin seq_p[idx] = c; idx++; end
    end else begin
      for (int k = 0; k < NWORDS; k++) begin
        seq_s[k] = 5;
        seq_p[k] = (k < 40) ? 9 : 10;
      end
    end
    for (int c = 0; c < NCODES; c++) begin m_start[c] = 0; m_stop[c] = 0; end
    for (int k = 0; k < NWORDS; k++) begin
      if (m_start[seq_s[k]] < CMAX) m_start[seq_s[k]]++;
      if (m_stop[seq_p[k]] < CMAX) m_stop[seq_p[k]]++;
    end
    @(negedge clk);
    learn_sel = 1'b1;
    repeat (2) @(negedge clk);
    if (probe) begin
      // R7: a request during the clear of a relearn is refused
      measure(0, 0, 0, 0, g, v, rj);
      chk(rj && !v, "R7", "request during relearn clear", {v, rj}, 1);
      learn_sel = 1'b1;
    end
    repeat (20) @(negedge clk);
    for (int k = 0; k < NWORDS + 6; k++) begin
      raw_valid = 1'b1;
      if (k < NWORDS) raw_word = {24'd7, seq_s[k][3:0], seq_p[k][3:0]};
      else            raw_word = {24'd7, 4'd2, 4'd14};
      @(negedge clk);
    end
    raw_valid = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    longint got, exp;
    bit v, rj;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!interval_valid && !reject, "R1", "outputs after reset", {interval_valid, reject}, 0);

    measure(3, 4, 5, 0, got, v, rj);
    chk(rj && !v, "R7", "request before any table", {v, rj}, 1);

    learn_run(0, 0);
    for (int i = 0; i < NV; i++) begin
      measure(V_COARSE[i], V_START[i], V_STOP[i], V_OFF[i], got, v, rj);
      exp = expect_ps(V_COARSE[i], V_START[i], V_STOP[i], V_OFF[i]);
      chk(v && !rj, "R2", $sformatf("valid vector %0d", i), {v, rj}, 2);
      chk(got == exp, "R2 R3 R5 R8 R9 R10", $sformatf("value vector %0d", i), got, exp);
    end

    // R8: exact half below zero rounds up to -1 (offset 24 gives -1.5 ps)
    measure(0, 0, 0, 24, got, v, rj);
    chk(got == -1, "R8", "half rounding negative", got, -1);
    // R10: an unhit top code sits at the full period
    measure(0, 0, 15, 0, got, v, rj);
    chk(got == -2000, "R10", "unhit top code", got, -2000);
    // R5: extra words on start code 2 must not change its centre
    measure(0, 2, 0, 0, got, v, rj);
    chk(got == expect_ps(0, 2, 0, 0), "R5", "extra words ignored", got, expect_ps(0, 2, 0, 0));

    learn_run(1, 1);
    // R6: start code 5 and stop code 9 both saturate at the maximum
    measure(0, 5, 9, 0, got, v, rj);
    chk(got == 0, "R6", "saturated pair", got, 0);
    measure(1, 5, 10, 0, got, v, rj);
    exp = expect_ps(1, 5, 10, 0);
    chk(got == exp, "R6 R9", "saturated prefix", got, exp);
    // R4: code 2 was busy only in the first run, so after the clear it has width zero
    measure(0, 2, 2, 0, got, v, rj);
    chk(got == 0 && v, "R4", "histogram cleared", got, 0);
    measure(0, 7, 1, 0, got, v, rj);
    exp = expect_ps(0, 7, 1, 0);
    chk(got == exp, "R4 R3", "centres after relearn", got, exp);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule